// File: doc/BRIEF.md
# Scanning Host Sequencer for an Eight-Input Serial Converter

This block runs on the system clock and drives an external eight-input, 10-bit serial converter. It generates the serial clock, the active-low select and the serial command line, and reads the returned bit stream. Each conversion slot lasts 16 serial clocks. During a slot the host sends a command byte that names the input to convert in the *next* slot. It also captures the 10-bit result of the input named in the *previous* slot. The block therefore keeps the previously requested input and attaches it to each returned result.

The host side loads an 8-bit enable mask, a continuous/single mode bit, and start and stop pulses. Enabled inputs are requested in ascending order and the order wraps around. In single mode every enabled input is requested once. One trailing slot then returns the last requested result, and the frame closes. In continuous mode, slots run back to back inside one select frame until a stop arrives. The current slot is then completed and the frame closes. Each finished slot produces a one-cycle result pulse with an input tag and a 10-bit code.

Top module: `adcscan_host`

## Requirements
- R1: After reset, spi_cs_n=1, spi_sclk=1, spi_mosi=0, busy=0 and res_valid=0.
- R2: While spi_cs_n is low, spi_sclk toggles every HALF_DIV system clocks, so the high and low phases are equal. spi_sclk is high whenever spi_cs_n is high. spi_cs_n changes only while spi_sclk is high. The first fall of spi_sclk comes HALF_DIV clocks after spi_cs_n falls. spi_cs_n rises HALF_DIV clocks after the last rise of spi_sclk.
- R3: Every frame (spi_cs_n low interval) holds a whole multiple of 16 rising edges of spi_sclk.
- R4: spi_mosi changes only on falling edges of spi_sclk. Per slot it carries an 8-bit command MSB first on rising edges 1 to 8, with the input number in command bits 5:3 (bit 5 most significant). All other command bits are 0, and spi_mosi is 0 on rising edges 9 to 16.
- R5: spi_miso is sampled on rising edges 5 to 14 of each slot, and the first sample is the most significant bit of res_data. res_valid pulses for one clock after the 16th rising edge of every slot.
- R6: res_chan is the input number sent in the slot before the one that returned the data, including a slot in an earlier frame. The first result after reset is tagged 0.
- R7: Inputs whose mask bit (bit i = input i) is set are requested in ascending order, wrapping from the highest enabled to the lowest. Disabled inputs are never requested. The mask is captured at start, and changes during a frame have no effect on it.
- R8: In single mode (cont_mode=0) a frame has one slot per enabled input, starting from the lowest. One extra slot follows, carrying the lowest enabled input, and then spi_cs_n rises.
- R9: In continuous mode (cont_mode=1) slots repeat until a stop pulse. The slot under way when stop arrives is completed, and then spi_cs_n rises.
- R10: A start pulse is ignored while busy is high, and also when chan_mask is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame (one-cycle pulse) |
| stop | input | 1 | End a continuous frame after the current slot |
| chan_mask | input | 8 | Enable bit per input, bit i for input i |
| cont_mode | input | 1 | 1 = continuous, 0 = single scan |
| spi_miso | input | 1 | Serial result bit from the converter |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_cs_n | output | 1 | Active-low select |
| spi_mosi | output | 1 | Serial command bit to the converter |
| busy | output | 1 | A frame is in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_chan | output | 3 | Input the result belongs to |
| res_data | output | 10 | Conversion code |

## Verification
A wrong slot-bit counter shows at the pins within one slot. The command bits would land on the wrong serial edges, the frame would close on a partial slot, or the result strobe would come early. A stale or mis-advanced previous-input register shows on res_chan at the very next result. It also shows on the first result of the next frame. A wrong scan pointer appears as an out-of-order or disabled input in the command stream of the next slot. An error in the single-scan termination shows as a wrong slot count when the frame closes.

// File: rtl/adcscan_pkg.sv
package adcscan_pkg;

    localparam int NUM_CH     = 8;
    localparam int CH_W       = $clog2(NUM_CH);
    localparam int CODE_W     = 10;
    localparam int SLOT_LEN   = 16;
    localparam int IDX_W      = $clog2(SLOT_LEN);
    localparam int LEAD_ZEROS = 4;
    localparam int CTRL_W     = 8;
    localparam int ADDR_LSB   = 3;

    typedef logic [CH_W-1:0]   chan_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [NUM_CH-1:0] mask_t;
    typedef logic [CTRL_W-1:0] ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_HOLD
    } seq_state_e;

    typedef struct packed {
        chan_t chan;
        code_t data;
    } result_t;

    typedef struct packed {
        logic  wrap;
        chan_t chan;
    } pick_t;

    // Lowest-numbered enabled input (0 when none).
    function automatic chan_t lowest_enabled(input mask_t m);
        chan_t r;
        r = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (m[i]) r = chan_t'(i);
        end
        return r;
    endfunction

    // Next enabled input above cur, wrapping; wrap flags passing the top.
    function automatic pick_t next_enabled(input mask_t m, input chan_t cur);
        pick_t p;
        logic  found;
        int    idx;
        p.wrap = 1'b1;
        p.chan = cur;
        found  = 1'b0;
        for (int i = 1; i < NUM_CH; i++) begin
            idx = int'(cur) + i;
            if (!found && m[idx % NUM_CH]) begin
                found  = 1'b1;
                p.chan = chan_t'(idx % NUM_CH);
                p.wrap = (idx >= NUM_CH);
            end
        end
        return p;
    endfunction

    // Command word: input number in its field, zeros elsewhere.
    function automatic ctrl_t command_word(input chan_t a);
        return ctrl_t'(a) << ADDR_LSB;
    endfunction

endpackage

// File: rtl/adcscan_sclk_gen.sv
module adcscan_sclk_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic sclk,
    output logic fall_now,
    output logic rise_now
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CNT_W-1:0] cnt;
    logic             sclk_q;
    logic             tick;

    assign tick     = run && (cnt == CNT_W'(HALF_DIV - 1));
    assign fall_now = tick && sclk_q;
    assign rise_now = tick && !sclk_q;
    assign sclk     = sclk_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt    <= '0;
            sclk_q <= 1'b1;
        end else if (tick) begin
            cnt    <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/adcscan_chan_track.sv
module adcscan_chan_track
    import adcscan_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  active,
    input  logic  load,
    input  mask_t mask_in,
    input  logic  cont_in,
    input  logic  slot_end,
    input  logic  frame_end,
    output chan_t cur_addr,
    output chan_t prev_chan,
    output logic  dummy_slot
);
    mask_t mask_q;
    logic  cont_q;
    pick_t pick;
    chan_t first_ch;

    always_comb begin
        pick     = next_enabled(mask_q, cur_addr);
        first_ch = lowest_enabled(mask_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q     <= '0;
            cont_q     <= 1'b0;
            cur_addr   <= '0;
            prev_chan  <= '0;
            dummy_slot <= 1'b0;
        end else if (load) begin
            mask_q     <= mask_in;
            cont_q     <= cont_in;
            cur_addr   <= lowest_enabled(mask_in);
            dummy_slot <= 1'b0;
        end else if (slot_end) begin
            prev_chan <= cur_addr;
            if (!frame_end) begin
                if (!cont_q && pick.wrap) begin
                    cur_addr   <= first_ch;
                    dummy_slot <= 1'b1;
                end else begin
                    cur_addr <= pick.chan;
                end
            end
        end
    end

    // R7: the requested input is always one the captured mask enables
    assert_addr_enabled_R7: assert property (@(posedge clk) disable iff (rst)
        active |-> mask_q[cur_addr]);

    // R8: the trailing slot exists only in single-scan frames
    assert_dummy_single_R8: assert property (@(posedge clk) disable iff (rst)
        dummy_slot |-> !cont_q);

endmodule

// File: rtl/adcscan_serdes.sv
module adcscan_serdes
    import adcscan_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fall_now,
    input  logic             rise_now,
    input  logic [IDX_W-1:0] rise_idx,
    input  chan_t            addr,
    input  logic             miso,
    output logic             mosi,
    output code_t            code
);
    localparam int SEL_W = $clog2(CTRL_W);

    ctrl_t            cmd;
    logic [SEL_W-1:0] sel;
    logic             in_cmd;
    logic             in_data;

    always_comb begin
        cmd     = command_word(addr);
        sel     = SEL_W'(CTRL_W - 1) - rise_idx[SEL_W-1:0];
        in_cmd  = rise_idx < IDX_W'(CTRL_W);
        in_data = (rise_idx >= IDX_W'(LEAD_ZEROS)) &&
                  (rise_idx <  IDX_W'(LEAD_ZEROS + CODE_W));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mosi <= 1'b0;
            code <= '0;
        end else begin
            if (fall_now) mosi <= in_cmd ? cmd[sel] : 1'b0;
            if (rise_now && in_data) code <= {code[CODE_W-2:0], miso};
        end
    end

endmodule

// File: rtl/adcscan_host.sv
module adcscan_host
    import adcscan_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             stop,
    input  logic [7:0]       chan_mask,
    input  logic             cont_mode,
    input  logic             spi_miso,
    output logic             spi_sclk,
    output logic             spi_cs_n,
    output logic             spi_mosi,
    output logic             busy,
    output logic             res_valid,
    output logic [2:0]       res_chan,
    output logic [9:0]       res_data
);
    localparam int HOLD_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    seq_state_e       state;
    logic [IDX_W-1:0] rise_idx;
    logic [HOLD_W-1:0] hold_cnt;
    logic             stop_req;
    logic             cs_n_q;
    logic             valid_q;
    result_t          res_q;

    logic  fall_now, rise_now, run;
    logic  start_ok, slot_end, frame_end;
    chan_t cur_addr, prev_chan;
    logic  dummy_slot;
    code_t code;

    assign run       = (state == ST_RUN);
    assign start_ok  = (state == ST_IDLE) && start && (|chan_mask);
    assign slot_end  = run && rise_now && (rise_idx == IDX_W'(SLOT_LEN - 1));
    assign frame_end = dummy_slot || stop_req || stop;

    adcscan_sclk_gen #(.HALF_DIV(HALF_DIV)) u_sclk (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .sclk     (spi_sclk),
        .fall_now (fall_now),
        .rise_now (rise_now)
    );

    adcscan_chan_track u_track (
        .clk        (clk),
        .rst        (rst),
        .active     (busy),
        .load       (start_ok),
        .mask_in    (chan_mask),
        .cont_in    (cont_mode),
        .slot_end   (slot_end),
        .frame_end  (frame_end),
        .cur_addr   (cur_addr),
        .prev_chan  (prev_chan),
        .dummy_slot (dummy_slot)
    );

    adcscan_serdes u_serdes (
        .clk      (clk),
        .rst      (rst),
        .fall_now (fall_now),
        .rise_now (rise_now),
        .rise_idx (rise_idx),
        .addr     (cur_addr),
        .miso     (spi_miso),
        .mosi     (spi_mosi),
        .code     (code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            rise_idx <= '0;
            hold_cnt <= '0;
            stop_req <= 1'b0;
            cs_n_q   <= 1'b1;
            valid_q  <= 1'b0;
            res_q    <= '0;
        end else begin
            valid_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    stop_req <= 1'b0;
                    if (start_ok) begin
                        cs_n_q   <= 1'b0;
                        rise_idx <= '0;
                        state    <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (stop) stop_req <= 1'b1;
                    if (rise_now) begin
                        if (slot_end) begin
                            rise_idx   <= '0;
                            valid_q    <= 1'b1;
                            res_q.chan <= prev_chan;
                            res_q.data <= code;
                            if (frame_end) begin
                                hold_cnt <= '0;
                                state    <= ST_HOLD;
                            end
                        end else begin
                            rise_idx <= rise_idx + 1'b1;
                        end
                    end
                end
                ST_HOLD: begin
                    if (hold_cnt == HOLD_W'(HALF_DIV - 1)) begin
                        cs_n_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else begin
                        hold_cnt <= hold_cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign spi_cs_n  = cs_n_q;
    assign busy      = (state != ST_IDLE);
    assign res_valid = valid_q;
    assign res_chan  = res_q.chan;
    assign res_data  = res_q.data;

    // R2: serial clock parks high outside a frame
    assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> spi_sclk);

    // R2: select moves only while the serial clock is high
    assert_cs_edge_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable(spi_cs_n) |-> (spi_sclk && $past(spi_sclk)));

    // R3: a frame closes only on a slot boundary
    assert_frame_whole_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_cs_n) |-> (rise_idx == '0));

    // R4: command line changes only with a falling serial clock
    assert_mosi_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(spi_mosi) |-> $fell(spi_sclk));

    // R5: one strobe per slot, never two in a row
    assert_result_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    // R10: an empty mask never opens a frame
    assert_empty_start_R10: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && (chan_mask == '0)) |=> !busy);

endmodule

// File: tb/tb_adcscan_host.sv
module tb_adcscan_host;
    localparam int HALF = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       stop = 1'b0;
    logic [7:0] chan_mask = '0;
    logic       cont_mode = 1'b0;
    logic       spi_miso = 1'b0;
    logic       spi_sclk, spi_cs_n, spi_mosi, busy, res_valid;
    logic [2:0] res_chan;
    logic [9:0] res_data;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    adcscan_host #(.HALF_DIV(HALF)) dut (
        .clk(clk), .rst(rst), .start(start), .stop(stop),
        .chan_mask(chan_mask), .cont_mode(cont_mode), .spi_miso(spi_miso),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .busy(busy), .res_valid(res_valid), .res_chan(res_chan), .res_data(res_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- converter model ----------------
    logic [2:0] m_conv_ch = 3'd0;   // powered-up input
    int         m_rise = 0, m_fall = 0, m_nconv = 0;
    logic [7:0] m_cmd = '0;
    logic [9:0] m_code = '0;

    logic [2:0] sent [0:511];
    int         nsent = 0;
    logic [2:0] e_ch  [0:511];
    logic [9:0] e_dat [0:511];
    int         e_wr = 0, e_rd = 0;
    int         first_tag = -1;

    function automatic logic [9:0] code_of(input int ch, input int n);
        return 10'((ch * 181 + n * 37 + 3) % 1024);
    endfunction

    always @(negedge spi_sclk) begin
        if (spi_cs_n === 1'b0) begin
            m_fall++;
            if (m_fall == 1) m_code = code_of(int'(m_conv_ch), m_nconv);
            if (m_fall >= 5 && m_fall <= 14) spi_miso = m_code[14 - m_fall];
            else spi_miso = 1'b0;
            if (m_fall == 16) m_fall = 0;
        end
    end

    always @(posedge spi_sclk) begin
        if (spi_cs_n === 1'b0) begin
            if (m_rise < 8) m_cmd[7 - m_rise] = spi_mosi;
            else chk(spi_mosi == 1'b0, "R4", "mosi after command", int'(spi_mosi), 0);
            m_rise++;
            if (m_rise == 16) begin
                chk((m_cmd & 8'hC7) == 8'h00, "R4", "unused command bits", int'(m_cmd), 0);
                sent[nsent] = m_cmd[5:3];
                nsent++;
                e_ch[e_wr]  = m_conv_ch;
                e_dat[e_wr] = m_code;
                e_wr++;
                m_nconv++;
                m_conv_ch = m_cmd[5:3];
                m_rise = 0;
            end
        end
    end

    always @(posedge spi_cs_n) begin
        if (!rst) chk(m_rise == 0, "R3", "rises left in partial slot", m_rise, 0);
        m_rise = 0;
        m_fall = 0;
    end

    // ---------------- result monitor (R5, R6) ----------------
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            if (first_tag < 0) first_tag = int'(res_chan);
            if (e_rd < e_wr) begin
                chk(res_chan == e_ch[e_rd], "R6", "result tag", int'(res_chan), int'(e_ch[e_rd]));
                chk(res_data == e_dat[e_rd], "R5", "result code", int'(res_data), int'(e_dat[e_rd]));
            end else begin
                chk(1'b0, "R5", "result without finished slot", e_rd, e_wr);
            end
            e_rd++;
        end
    end

    // ---------------- pin timing monitor (R2) ----------------
    int   seg = 0;
    logic p_sclk = 1'b1, p_cs = 1'b1;
    always @(negedge clk) begin
        if (rst) begin
            seg = 0; p_sclk = 1'b1; p_cs = 1'b1;
        end else begin
            if (spi_sclk !== p_sclk) begin
                chk(seg == HALF, "R2", "sclk phase length", seg, HALF);
                chk(spi_cs_n == 1'b0, "R2", "sclk toggled with cs high", int'(spi_cs_n), 0);
                seg = 1;
            end else if (spi_cs_n !== p_cs) begin
                chk(spi_sclk == 1'b1, "R2", "sclk level at cs edge", int'(spi_sclk), 1);
                if (spi_cs_n) chk(seg == HALF, "R2", "cs hold after last rise", seg, HALF);
                seg = 1;
            end else begin
                seg++;
            end
            p_sclk = spi_sclk;
            p_cs   = spi_cs_n;
        end
    end

    // ---------------- helpers ----------------
    function automatic int nth_enabled(input logic [7:0] m, input int k);
        int pop, want, seen;
        pop = $countones(m);
        want = k % pop;
        seen = 0;
        for (int i = 0; i < 8; i++) begin
            if (m[i]) begin
                if (seen == want) return i;
                seen++;
            end
        end
        return 0;
    endfunction

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        @(negedge clk);
        while (busy && n < 20000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic check_single_order(input logic [7:0] m, input int base, input string req);
        int pop;
        pop = $countones(m);
        chk(nsent - base == pop + 1, "R8", "slots in single frame", nsent - base, pop + 1);
        for (int k = 0; k < pop && base + k < nsent; k++)
            chk(sent[base + k] == 3'(nth_enabled(m, k)), req, "scan order",
                int'(sent[base + k]), nth_enabled(m, k));
        if (nsent - base == pop + 1)
            chk(sent[base + pop] == 3'(nth_enabled(m, 0)), "R8", "trailing slot input",
                int'(sent[base + pop]), nth_enabled(m, 0));
        chk(e_rd == e_wr, "R5", "one strobe per slot", e_rd, e_wr);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk(spi_cs_n == 1'b1, "R1", "cs after reset", int'(spi_cs_n), 1);
        chk(spi_sclk == 1'b1, "R1", "sclk after reset", int'(spi_sclk), 1);
        chk(spi_mosi == 1'b0, "R1", "mosi after reset", int'(spi_mosi), 0);
        chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
        chk(res_valid == 1'b0, "R1", "valid after reset", int'(res_valid), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_single(input logic [7:0] m);
        int base = nsent;
        chan_mask = m; cont_mode = 1'b0;
        pulse_start();
        wait_idle();
        check_single_order(m, base, "R7");
    endtask

    task automatic t_first_tag();
        t_single(8'b1010_0100);
        chk(first_tag == 0, "R6", "first tag after reset", first_tag, 0);
    endtask

    task automatic t_mask_change();
        int base = nsent;
        chan_mask = 8'b0100_1001; cont_mode = 1'b0;
        pulse_start();
        repeat (40) @(negedge clk);
        chan_mask = 8'b0011_0110;   // must not alter the running scan (R7)
        wait_idle();
        check_single_order(8'b0100_1001, base, "R7");
    endtask

    task automatic t_cont(input logic [7:0] m, input int nslots);
        int base = nsent;
        int n = 0;
        chan_mask = m; cont_mode = 1'b1;
        pulse_start();
        while (nsent - base < nslots && n < 50000) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk) stop = 1'b1;
        @(negedge clk) stop = 1'b0;
        wait_idle();
        chk(nsent - base == nslots + 1, "R9", "slots before stop took effect",
            nsent - base, nslots + 1);
        for (int k = 0; k < nsent - base; k++)
            chk(sent[base + k] == 3'(nth_enabled(m, k)), "R9", "continuous wrap order",
                int'(sent[base + k]), nth_enabled(m, k));
        chk(e_rd == e_wr, "R5", "one strobe per slot", e_rd, e_wr);
        cont_mode = 1'b0;
    endtask

    task automatic t_ignored_starts();
        int base = nsent;
        chan_mask = 8'h00;
        pulse_start();
        repeat (20) @(negedge clk);
        chk(busy == 1'b0, "R10", "busy after empty-mask start", int'(busy), 0);
        chk(spi_cs_n == 1'b1, "R10", "cs after empty-mask start", int'(spi_cs_n), 1);
        chk(nsent == base, "R10", "slots after empty-mask start", nsent - base, 0);
        chan_mask = 8'b0001_0010; cont_mode = 1'b0;
        pulse_start();
        repeat (50) @(negedge clk);
        pulse_start();              // ignored while busy
        wait_idle();
        chk(nsent - base == 3, "R10", "slots with start while busy", nsent - base, 3);
        check_single_order(8'b0001_0010, base, "R10");
    endtask

    // ---------------- run ----------------
    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_first_tag();
        t_single(8'hFF);
        t_single(8'h80);
        t_single(8'h01);
        t_mask_change();
        t_cont(8'b1001_0010, 7);
        t_cont(8'b0000_1000, 3);
        t_ignored_starts();
        t_single(8'b0110_0000);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, got %0d expected %0d", 0, 1);
            finish_run();
        end
    end

endmodule